// File: doc/BRIEF.md
# Private Interrupt Winner Selector

This block holds the pending and active state of the private interrupts of one processor and picks the one that should be presented to that processor's interface. It has 32 interrupts by default. For each interrupt it receives an enable bit, an 8-bit priority and a 2-bit group code. Each group also has a global enable. A two-stage comparison tree reduces the eligible interrupts to a single winner, which is given as an ID, a priority and a group. A valid flag is asserted only when the result matches the current state.

Software can set pending bits directly. Peripheral inputs set pending bits only in the upper half of the ID range. The processor interface sends activate and deactivate commands, one ID per cycle. Every interrupt also reports a 2-bit status. All outputs are plain registered levels. The block has no stream interface, so it applies no back-pressure: the consumer reads the winner whenever the valid flag is high.

Top module: `hpi_select`

## Requirements
- R1: An interrupt can win only when it is pending, enabled and not active, and its group code indexes a set bit of `group_enable`. Code 0 selects bit 0, code 1 selects bit 1 and code 2 selects bit 2. Code 3 is never eligible.
- R2: Among eligible interrupts, the one with the numerically smallest priority value wins.
- R3: When two eligible interrupts have the same priority, the lower ID wins.
- R4: When no interrupt is eligible, `sel_prio` reads 0xFF, `sel_id` and `sel_group` read 0, and `sel_valid` is low.
- R5: An activate command (`cmd_deact`=0) clears the pending bit of `cmd_id` and sets its active bit. A deactivate command (`cmd_deact`=1) clears only the active bit.
- R6: `irq_status[2i+1:2i]` is {active, pending} of interrupt i: 0 means inactive, 1 pending, 2 active, 3 active and pending.
- R7: `set_pend[i]` sets the pending bit of interrupt i. `periph_in[k]` sets the pending bit of interrupt 16+k.
- R8: A change sampled at clock edge E appears on `sel_id`, `sel_prio` and `sel_group` after edge E+2. Before that, these outputs keep their old values.
- R9: `sel_valid` is low in the two cycles after any event. An event is a command, a pending set, or a change on any configuration input.
- R10: If a pending set for an ID arrives in the same cycle as a command for that ID, the set is applied after the command. An activate plus a set therefore leaves the interrupt both active and pending.
- R11: After reset all pending and active bits are clear and every status field reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_enable | input | 32 | Per-interrupt enable |
| irq_prio | input | 256 | Priority of interrupt i in bits [8i+7:8i] |
| irq_group | input | 64 | Group code of interrupt i in bits [2i+1:2i] |
| group_enable | input | 3 | Global enable, indexed by group code |
| set_pend | input | 32 | One-cycle pending-set strobes |
| periph_in | input | 16 | One-cycle peripheral strobes for IDs 16..31 |
| cmd_valid | input | 1 | Command strobe |
| cmd_deact | input | 1 | 0 = activate, 1 = deactivate |
| cmd_id | input | 5 | ID the command applies to |
| sel_valid | output | 1 | Winner present and result settled |
| sel_id | output | 5 | Winning ID |
| sel_prio | output | 8 | Winning priority, 0xFF when none |
| sel_group | output | 2 | Winning group code |
| irq_status | output | 64 | {active, pending} per interrupt |

## Verification
The assertions assume that `cmd_id` is below the interrupt count. They also assume that the configuration inputs change only in the cycles where an event is intended, since every change is treated as an event. The stimulus drives all inputs on the falling edge and applies at most one command per cycle. After each event it holds the inputs steady until the result has settled. Before each next step it samples `sel_valid` and the old winner during the two-cycle re-evaluation window.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  localparam int GRP_W = 2;
  typedef enum logic [GRP_W-1:0] {
    GRP_ZERO  = 2'd0,
    GRP_ONE_S = 2'd1,
    GRP_ONE_N = 2'd2,
    GRP_NONE  = 2'd3
  } grp_code_e;
  typedef enum logic {
    CMD_ACTIVATE   = 1'b0,
    CMD_DEACTIVATE = 1'b1
  } cmd_op_e;
endpackage

// File: rtl/hpi_state.sv
module hpi_state
  import hpi_pkg::*;
#(
  parameter int NUM_IRQ     = 32,
  parameter int PERIPH_BASE = 16,
  parameter int PERIPH_NUM  = 16,
  parameter int ID_W        = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IRQ-1:0]   set_pend,
  input  logic [PERIPH_NUM-1:0] periph_in,
  input  logic                 cmd_valid,
  input  logic                 cmd_deact,
  input  logic [ID_W-1:0]      cmd_id,
  output logic [NUM_IRQ-1:0]   pend_q,
  output logic [NUM_IRQ-1:0]   act_q,
  output logic [2*NUM_IRQ-1:0] status,
  output logic                 state_ev
);
  logic [NUM_IRQ-1:0] set_all, pend_n, act_n;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    if (i >= PERIPH_BASE && i < PERIPH_BASE + PERIPH_NUM) begin : g_periph
      assign set_all[i] = set_pend[i] | periph_in[i-PERIPH_BASE];
    end else begin : g_soft
      assign set_all[i] = set_pend[i];
    end
    assign status[2*i +: 2] = {act_q[i], pend_q[i]};
  end

  // command first, pending set afterwards (R10)
  always_comb begin
    pend_n = pend_q;
    act_n  = act_q;
    if (cmd_valid && int'(cmd_id) < NUM_IRQ) begin
      if (cmd_op_e'(cmd_deact) == CMD_DEACTIVATE) begin
        act_n[cmd_id] = 1'b0;
      end else begin
        pend_n[cmd_id] = 1'b0;
        act_n[cmd_id]  = 1'b1;
      end
    end
    pend_n = pend_n | set_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_n;
      act_q  <= act_n;
    end
  end

  assign state_ev = cmd_valid | (|set_all);

  assert_activate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_deact && !set_all[cmd_id])
      |=> (act_q[$past(cmd_id)] && !pend_q[$past(cmd_id)]));

  assert_deactivate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_deact)
      |=> (!act_q[$past(cmd_id)] &&
           pend_q[$past(cmd_id)] == ($past(pend_q[cmd_id]) | $past(set_all[cmd_id]))));

  assert_set_after_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_deact && set_all[cmd_id])
      |=> (act_q[$past(cmd_id)] && pend_q[$past(cmd_id)]));
endmodule

// File: rtl/hpi_cand.sv
module hpi_cand
  import hpi_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int NUM_GRP = 3
) (
  input  logic [NUM_IRQ-1:0]       pend,
  input  logic [NUM_IRQ-1:0]       act,
  input  logic [NUM_IRQ-1:0]       en,
  input  logic [GRP_W*NUM_IRQ-1:0] grp,
  input  logic [NUM_GRP-1:0]       grp_en,
  output logic [NUM_IRQ-1:0]       cand
);
  localparam int CODES = 1 << GRP_W;
  logic [CODES-1:0] grp_en_ext;

  for (genvar c = 0; c < CODES; c++) begin : g_code
    if (c < NUM_GRP) begin : g_used
      assign grp_en_ext[c] = grp_en[c];
    end else begin : g_unused
      assign grp_en_ext[c] = 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign cand[i] = pend[i] & en[i] & ~act[i] & grp_en_ext[grp[GRP_W*i +: GRP_W]];
  end
endmodule

// File: rtl/hpi_tree.sv
module hpi_tree
  import hpi_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int LANES   = 4,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        cand,
  input  logic [PRIO_W*NUM_IRQ-1:0] prio,
  input  logic [GRP_W*NUM_IRQ-1:0]  grp,
  output logic                      win_hit,
  output logic [PRIO_W-1:0]         win_prio,
  output logic [ID_W-1:0]           win_id,
  output logic [GRP_W-1:0]          win_grp
);
  localparam int LANE_SZ = NUM_IRQ / LANES;

  logic              l_hit_q  [LANES];
  logic [PRIO_W-1:0] l_prio_q [LANES];
  logic [ID_W-1:0]   l_id_q   [LANES];
  logic [GRP_W-1:0]  l_grp_q  [LANES];

  // stage 1: one winner per lane, ascending scan with strict compare
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              b_hit;
    logic [PRIO_W-1:0] b_prio;
    logic [ID_W-1:0]   b_id;
    logic [GRP_W-1:0]  b_grp;

    always_comb begin
      b_hit  = 1'b0;
      b_prio = '1;
      b_id   = '0;
      b_grp  = '0;
      for (int j = 0; j < LANE_SZ; j++) begin
        if (cand[g*LANE_SZ+j] &&
            (!b_hit || prio[(g*LANE_SZ+j)*PRIO_W +: PRIO_W] < b_prio)) begin
          b_hit  = 1'b1;
          b_prio = prio[(g*LANE_SZ+j)*PRIO_W +: PRIO_W];
          b_id   = ID_W'(g*LANE_SZ+j);
          b_grp  = grp[(g*LANE_SZ+j)*GRP_W +: GRP_W];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        l_hit_q[g]  <= 1'b0;
        l_prio_q[g] <= '1;
        l_id_q[g]   <= '0;
        l_grp_q[g]  <= '0;
      end else begin
        l_hit_q[g]  <= b_hit;
        l_prio_q[g] <= b_prio;
        l_id_q[g]   <= b_id;
        l_grp_q[g]  <= b_grp;
      end
    end
  end

  // stage 2: lanes in ascending ID order, strict compare keeps lowest ID
  logic              f_hit;
  logic [PRIO_W-1:0] f_prio;
  logic [ID_W-1:0]   f_id;
  logic [GRP_W-1:0]  f_grp;

  always_comb begin
    f_hit  = 1'b0;
    f_prio = '1;
    f_id   = '0;
    f_grp  = '0;
    for (int g = 0; g < LANES; g++) begin
      if (l_hit_q[g] && (!f_hit || l_prio_q[g] < f_prio)) begin
        f_hit  = 1'b1;
        f_prio = l_prio_q[g];
        f_id   = l_id_q[g];
        f_grp  = l_grp_q[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_hit  <= 1'b0;
      win_prio <= '1;
      win_id   <= '0;
      win_grp  <= '0;
    end else begin
      win_hit  <= f_hit;
      win_prio <= f_prio;
      win_id   <= f_id;
      win_grp  <= f_grp;
    end
  end
endmodule

// File: rtl/hpi_select.sv
module hpi_select
  import hpi_pkg::*;
#(
  parameter int NUM_IRQ     = 32,
  parameter int PRIO_W      = 8,
  parameter int LANES       = 4,
  parameter int PERIPH_BASE = 16,
  parameter int PERIPH_NUM  = 16,
  parameter int NUM_GRP     = 3,
  localparam int ID_W       = $clog2(NUM_IRQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        irq_enable,
  input  logic [PRIO_W*NUM_IRQ-1:0] irq_prio,
  input  logic [2*NUM_IRQ-1:0]      irq_group,
  input  logic [NUM_GRP-1:0]        group_enable,
  input  logic [NUM_IRQ-1:0]        set_pend,
  input  logic [PERIPH_NUM-1:0]     periph_in,
  input  logic                      cmd_valid,
  input  logic                      cmd_deact,
  input  logic [ID_W-1:0]           cmd_id,
  output logic                      sel_valid,
  output logic [ID_W-1:0]           sel_id,
  output logic [PRIO_W-1:0]         sel_prio,
  output logic [1:0]                sel_group,
  output logic [2*NUM_IRQ-1:0]      irq_status
);
  logic [NUM_IRQ-1:0]        en_q;
  logic [PRIO_W*NUM_IRQ-1:0] prio_q;
  logic [GRP_W*NUM_IRQ-1:0]  grp_q;
  logic [NUM_GRP-1:0]        gen_q;
  logic [NUM_IRQ-1:0]        pend_q, act_q, cand_vec;
  logic                      state_ev, cfg_ev, ev, ev_d1, settle_q, win_hit;

  // configuration registered so every input sees the same two-edge latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      prio_q <= '0;
      grp_q  <= '0;
      gen_q  <= '0;
    end else begin
      en_q   <= irq_enable;
      prio_q <= irq_prio;
      grp_q  <= irq_group;
      gen_q  <= group_enable;
    end
  end

  assign cfg_ev = (irq_enable != en_q) | (irq_prio != prio_q) |
                  (irq_group != grp_q) | (group_enable != gen_q);
  assign ev = state_ev | cfg_ev;

  hpi_state #(
    .NUM_IRQ(NUM_IRQ), .PERIPH_BASE(PERIPH_BASE),
    .PERIPH_NUM(PERIPH_NUM), .ID_W(ID_W)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .set_pend(set_pend), .periph_in(periph_in),
    .cmd_valid(cmd_valid), .cmd_deact(cmd_deact), .cmd_id(cmd_id),
    .pend_q(pend_q), .act_q(act_q), .status(irq_status), .state_ev(state_ev)
  );

  hpi_cand #(.NUM_IRQ(NUM_IRQ), .NUM_GRP(NUM_GRP)) u_cand (
    .pend(pend_q), .act(act_q), .en(en_q), .grp(grp_q),
    .grp_en(gen_q), .cand(cand_vec)
  );

  hpi_tree #(
    .NUM_IRQ(NUM_IRQ), .LANES(LANES), .PRIO_W(PRIO_W), .ID_W(ID_W)
  ) u_tree (
    .clk(clk), .rst_n(rst_n), .cand(cand_vec), .prio(prio_q), .grp(grp_q),
    .win_hit(win_hit), .win_prio(sel_prio), .win_id(sel_id), .win_grp(sel_group)
  );

  // settled only when no event was sampled at this edge nor the one before
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_d1    <= 1'b1;
      settle_q <= 1'b0;
    end else begin
      ev_d1    <= ev;
      settle_q <= !ev && !ev_d1;
    end
  end

  assign sel_valid = settle_q & win_hit;

  // checker: is there an eligible interrupt that beats the reported one
  logic better;
  always_comb begin
    better = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand_vec[i] &&
          (prio_q[i*PRIO_W +: PRIO_W] < sel_prio ||
           (prio_q[i*PRIO_W +: PRIO_W] == sel_prio && ID_W'(i) < sel_id)))
        better = 1'b1;
    end
  end

  assert_winner_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> cand_vec[sel_id]);

  // also covers the lowest-ID tie rule of R3
  assert_best_choice_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> !better);

  assert_empty_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q && cand_vec == '0) |-> (sel_prio == '1 && !sel_valid));

  assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev |-> ##1 !sel_valid ##1 !sel_valid);
endmodule

// File: tb/hpi_select_tb.sv
`timescale 1ns/1ps
module hpi_select_tb;
  localparam int N = 32;

  typedef struct packed {
    logic        v;
    logic [4:0]  id;
    logic [7:0]  prio;
    logic [1:0]  grp;
    logic [63:0] st;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]   en;
  logic [7:0]     pr [N];
  logic [1:0]     gr [N];
  logic [2:0]     gen;
  logic [N-1:0]   setp;
  logic [15:0]    per;
  logic           cv, cd;
  logic [4:0]     cid;
  logic [N*8-1:0] pr_flat;
  logic [N*2-1:0] gr_flat;

  logic        sel_valid;
  logic [4:0]  sel_id;
  logic [7:0]  sel_prio;
  logic [1:0]  sel_group;
  logic [63:0] irq_status;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      pr_flat[i*8 +: 8] = pr[i];
      gr_flat[i*2 +: 2] = gr[i];
    end
  end

  hpi_select u_dut (
    .clk(clk), .rst_n(rst_n), .irq_enable(en), .irq_prio(pr_flat),
    .irq_group(gr_flat), .group_enable(gen), .set_pend(setp), .periph_in(per),
    .cmd_valid(cv), .cmd_deact(cd), .cmd_id(cid), .sel_valid(sel_valid),
    .sel_id(sel_id), .sel_prio(sel_prio), .sel_group(sel_group),
    .irq_status(irq_status)
  );

  logic [N-1:0] m_pend, m_act;
  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  logic [4:0] last_id;

  task automatic chk(bit ok, string req, string what, logic [79:0] act_v, logic [79:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  function automatic exp_t model_expect();
    exp_t e;
    logic [3:0] gx;
    gx = {1'b0, gen};
    e.v = 1'b0; e.id = '0; e.prio = 8'hFF; e.grp = '0;
    for (int i = 0; i < N; i++) begin
      if (m_pend[i] && en[i] && !m_act[i] && gx[gr[i]] &&
          (!e.v || pr[i] < e.prio)) begin
        e.v = 1'b1; e.id = 5'(i); e.prio = pr[i]; e.grp = gr[i];
      end
    end
    for (int i = 0; i < N; i++) e.st[2*i +: 2] = {m_act[i], m_pend[i]};
    return e;
  endfunction

  // monitor: compares queued expectations with the outputs
  initial begin
    exp_t e;
    string t;
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(sel_valid == e.v && sel_id == e.id && sel_prio == e.prio && sel_group == e.grp,
            t, "winner", {sel_valid, sel_id, sel_prio, sel_group}, {e.v, e.id, e.prio, e.grp});
        chk(irq_status == e.st, t, "status (R6)", irq_status, e.st);
      end
    end
  end

  // driver: inputs were set at the current falling edge; model, then schedule
  task automatic step(string tag);
    exp_t e;
    if (cv) begin
      if (cd) m_act[cid] = 1'b0;
      else begin m_pend[cid] = 1'b0; m_act[cid] = 1'b1; end
    end
    m_pend = m_pend | setp | (N'(per) << 16);
    @(negedge clk);
    setp = '0; per = '0; cv = 1'b0;
    chk(sel_valid == 1'b0, "R9", "valid first cycle", sel_valid, 0);
    chk(sel_id == last_id, "R8", "old id first cycle", sel_id, last_id);
    @(negedge clk);
    chk(sel_valid == 1'b0, "R9", "valid second cycle", sel_valid, 0);
    chk(sel_id == last_id, "R8", "old id second cycle", sel_id, last_id);
    @(negedge clk);
    e = model_expect();
    exp_q.push_back(e);
    tag_q.push_back(tag);
    last_id = e.id;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t e;
    en = '0; gen = '0; setp = '0; per = '0; cv = 0; cd = 0; cid = '0;
    for (int i = 0; i < N; i++) begin pr[i] = '0; gr[i] = '0; end
    m_pend = '0; m_act = '0; last_id = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(irq_status == '0, "R11", "status after reset", irq_status, 0);
    e = model_expect();
    exp_q.push_back(e); tag_q.push_back("R11 reset / R4 empty");
    @(negedge clk);

    en = '1; gen = 3'b111;
    for (int i = 0; i < N; i++) begin pr[i] = 8'hC0; gr[i] = 2'(i % 3); end
    pr[3] = 8'h40; pr[7] = 8'h20; pr[5] = 8'h20; pr[18] = 8'h10;
    step("R4 configured, nothing pending");

    setp = (N'(1) << 3) | (N'(1) << 7);
    step("R2 smaller value wins");

    setp = N'(1) << 5;
    step("R3 tie to lower ID");

    per = 16'h0004;
    step("R7 peripheral input sets ID 18");

    cv = 1; cd = 0; cid = 5'd18;
    step("R5 activate clears pending");

    setp = N'(1) << 18;
    step("R1 active interrupt excluded");

    cv = 1; cd = 1; cid = 5'd18;
    step("R5 deactivate keeps pending");

    en[18] = 1'b0;
    step("R1 disabled interrupt excluded");

    gen = 3'b011;
    step("R1 group disabled");

    gr[7] = 2'd3;
    step("R1 reserved group code");

    gen = 3'b111;
    step("R1 group re-enabled");

    cv = 1; cd = 0; cid = 5'd5; setp = N'(1) << 5;
    step("R10 set applied after activate");

    cv = 1; cd = 1; cid = 5'd5;
    step("R5 deactivate with pending left");

    cv = 1; cd = 0; cid = 5'd5;
    step("R5 activate winner");

    cv = 1; cd = 0; cid = 5'd3;
    step("R4 no candidate left");

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule